// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block sits beside a four-core processor cluster and decides, for each core, which interrupt sources raise that core's normal interrupt line (IRQ) and which raise its fast interrupt line (FIQ). Each core brings in four level-sensitive timer interrupt lines. The mailbox block supplies four pending flags per core. A single shared upstream IRQ/FIQ pair comes from the system-level interrupt controller.

Software configures the router through a 32-bit register bus. Each core has one control byte for its timer sources and one for its mailbox sources. For each source, the control byte selects FIQ, IRQ or masked. The upstream pair bypasses all masking and goes to a programmable target core. Two read-only source registers per core show which sources are currently steering to that core's IRQ and FIQ. These registers are recomputed every cycle from the live input levels. Each core output is the registered OR of its source register.

Top module: `local_irq_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, the route fields and all control bytes clear and `core_irq`/`core_fiq` go low. Afterwards every configuration register reads zero.
- R2: The timer control byte of core c is at offset 0x40+4c and the mailbox control byte at 0x50+4c. A write keeps `wdata[7:0]` and drops the rest. A read returns the byte zero-extended.
- R3: The route register at offset 0x0C holds the upstream IRQ target core in bits [1:0] and the upstream FIQ target core in bits [3:2]. Other written bits are dropped, and a read returns the same layout.
- R4: An active timer line j (0..3) of core c sets source bit j: in the IRQ source register when control bit j is set, and in the FIQ source register when control bit j+4 is set.
- R5: A source whose FIQ bit (j+4) is set goes to FIQ only, whatever its IRQ bit (j) holds.
- R6: A source with both of its control bits clear contributes to neither source register, whatever its level.
- R7: Pending mailbox flag j of core c is steered by that core's mailbox control byte, using the same bit pairs as R4/R5, onto source bit 4+j.
- R8: The upstream IRQ (FIQ) input, while high, sets bit 8 of the IRQ (FIQ) source register of the core its route field names, with no mask applied.
- R9: `core_irq[c]` (`core_fiq[c]`) is high in the cycle after the one in which core c's IRQ (FIQ) source register is nonzero, and low otherwise. There is no edge detection.
- R10: The IRQ source register of core c reads at 0x60+4c and the FIQ source register at 0x70+4c, with bits [8:0] as in R4, R7 and R8. Both reflect the current inputs, and writes to them change nothing.
- R11: An access whose offset is not word aligned, or that matches none of the registers above, reads zero, and a write to it changes no register.
- R12: `bus_rdata` is registered. It carries the addressed value in the cycle after `bus_rd_en` is sampled high, and zero in a cycle after `bus_rd_en` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| timer_lvl | input | NUM_CORES*4 | Timer interrupt levels, core c line j at bit 4c+j |
| mbox_pend | input | NUM_CORES*4 | Mailbox pending flags, core c mailbox j at bit 4c+j |
| up_irq | input | 1 | Upstream interrupt request level |
| up_fiq | input | 1 | Upstream fast interrupt request level |
| core_irq | output | NUM_CORES | Per-core IRQ output |
| core_fiq | output | NUM_CORES | Per-core FIQ output |

## Verification
A control-byte write and an already active source can meet in the same cycle. The output must then follow the old control value at the write edge and the new one from the next edge onward. The bench holds a timer line high with IRQ enabled and clears the control byte. It checks that `core_irq` is still high right after the write edge and low one edge later. Upstream and local sources can also land on the same core in one cycle, one on IRQ and one on FIQ. The vector table provokes this case and judges both source registers and both output lines together.

// File: rtl/lir_pkg.sv
// Package: shared constants, region decode and types for the local
// interrupt router. Assumes at most four cores (2-bit route fields).
package lir_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int CTL_W      = 8;   // control byte width
    localparam int LOCAL_N    = 4;   // timer lines / mailboxes per core
    localparam int SRC_W      = 9;   // source register width
    localparam int TMR_BASE   = 0;   // first timer source bit
    localparam int MBX_BASE   = 4;   // first mailbox source bit
    localparam int UP_BIT     = 8;   // upstream source bit
    localparam int CORE_IDX_W = 2;   // route field width
    localparam int FIQ_OFS    = 4;   // FIQ enable bit offset in control byte

    typedef enum logic [2:0] {
        RG_NONE, RG_ROUTE, RG_TCTL, RG_MCTL, RG_ISRC, RG_FSRC
    } region_e;

    // Classify a byte offset into a register region.
    function automatic region_e lir_region(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00) return RG_NONE;
        case (a[7:4])
            4'h0:    return (a[3:0] == 4'hC) ? RG_ROUTE : RG_NONE;
            4'h4:    return RG_TCTL;
            4'h5:    return RG_MCTL;
            4'h6:    return RG_ISRC;
            4'h7:    return RG_FSRC;
            default: return RG_NONE;
        endcase
    endfunction
endpackage

// File: rtl/lir_ctrl_regs.sv
// Module: writable configuration of the router (route fields, timer and
// mailbox control bytes). Assumes NUM_CORES <= 4; core index = addr[3:2].
module lir_ctrl_regs
    import lir_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [CTL_W-1:0]                    wdata,
    output logic [CORE_IDX_W-1:0]               route_irq,
    output logic [CORE_IDX_W-1:0]               route_fiq,
    output logic [NUM_CORES-1:0][CTL_W-1:0]     tctl,
    output logic [NUM_CORES-1:0][CTL_W-1:0]     mctl
);
    region_e                 region;
    logic [CORE_IDX_W-1:0]   core_sel;

    // Decode the target region of the current access.
    always_comb begin
        region   = lir_region(addr);
        core_sel = addr[3:2];
    end

    // Capture writes into route and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_irq <= '0;
            route_fiq <= '0;
            tctl      <= '0;
            mctl      <= '0;
        end else if (wr_en) begin
            case (region)
                RG_ROUTE: begin
                    route_irq <= wdata[1:0];
                    route_fiq <= wdata[3:2];
                end
                RG_TCTL: begin
                    for (int c = 0; c < NUM_CORES; c++)
                        if (int'(core_sel) == c) tctl[c] <= wdata;
                end
                RG_MCTL: begin
                    for (int c = 0; c < NUM_CORES; c++)
                        if (int'(core_sel) == c) mctl[c] <= wdata;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lir_core_steer.sv
// Module: steering for one core. Each active source goes to FIQ when its
// FIQ enable bit is set, else to IRQ when its IRQ bit is set, else nowhere.
// Upstream hits arrive already routed and are never masked. Purely combinational.
module lir_core_steer
    import lir_pkg::*;
(
    input  logic [LOCAL_N-1:0] timer,
    input  logic [LOCAL_N-1:0] mbox,
    input  logic [CTL_W-1:0]   tctl,
    input  logic [CTL_W-1:0]   mctl,
    input  logic               up_irq_hit,
    input  logic               up_fiq_hit,
    output logic [SRC_W-1:0]   isrc,
    output logic [SRC_W-1:0]   fsrc
);
    // Build the IRQ and FIQ source vectors from levels and control bytes.
    always_comb begin
        isrc = '0;
        fsrc = '0;
        for (int j = 0; j < LOCAL_N; j++) begin
            if (timer[j]) begin
                if (tctl[j+FIQ_OFS])  fsrc[TMR_BASE+j] = 1'b1;
                else if (tctl[j])     isrc[TMR_BASE+j] = 1'b1;
            end
            if (mbox[j]) begin
                if (mctl[j+FIQ_OFS])  fsrc[MBX_BASE+j] = 1'b1;
                else if (mctl[j])     isrc[MBX_BASE+j] = 1'b1;
            end
        end
        isrc[UP_BIT] = up_irq_hit;
        fsrc[UP_BIT] = up_fiq_hit;
    end
endmodule

// File: rtl/lir_read_mux.sv
// Module: read-data selection over all router registers; unmapped or
// misaligned offsets give zero. Combinational; the top registers it.
module lir_read_mux
    import lir_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic [CORE_IDX_W-1:0]           route_irq,
    input  logic [CORE_IDX_W-1:0]           route_fiq,
    input  logic [NUM_CORES-1:0][CTL_W-1:0] tctl,
    input  logic [NUM_CORES-1:0][CTL_W-1:0] mctl,
    input  logic [NUM_CORES-1:0][SRC_W-1:0] isrc,
    input  logic [NUM_CORES-1:0][SRC_W-1:0] fsrc,
    output logic [DATA_W-1:0]               rdata
);
    region_e               region;
    logic [CORE_IDX_W-1:0] core_sel;

    // Select the addressed register, zero-extended.
    always_comb begin
        region   = lir_region(addr);
        core_sel = addr[3:2];
        rdata    = '0;
        case (region)
            RG_ROUTE: rdata = {{(DATA_W-2*CORE_IDX_W){1'b0}}, route_fiq, route_irq};
            RG_TCTL, RG_MCTL, RG_ISRC, RG_FSRC: begin
                for (int c = 0; c < NUM_CORES; c++) begin
                    if (int'(core_sel) == c) begin
                        case (region)
                            RG_TCTL: rdata = {{(DATA_W-CTL_W){1'b0}}, tctl[c]};
                            RG_MCTL: rdata = {{(DATA_W-CTL_W){1'b0}}, mctl[c]};
                            RG_ISRC: rdata = {{(DATA_W-SRC_W){1'b0}}, isrc[c]};
                            default: rdata = {{(DATA_W-SRC_W){1'b0}}, fsrc[c]};
                        endcase
                    end
                end
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/local_irq_router.sv
// Module: top of the per-core local interrupt router. Assumes synchronous
// active-low reset and NUM_CORES <= 4. Outputs and read data are registered.
module local_irq_router
    import lir_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int LVL_W    = NUM_CORES * LOCAL_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_en,
    input  logic                 bus_rd_en,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [LVL_W-1:0]     timer_lvl,
    input  logic [LVL_W-1:0]     mbox_pend,
    input  logic                 up_irq,
    input  logic                 up_fiq,
    output logic [NUM_CORES-1:0] core_irq,
    output logic [NUM_CORES-1:0] core_fiq
);
    logic [CORE_IDX_W-1:0]               route_irq_tgt;
    logic [CORE_IDX_W-1:0]               route_fiq_tgt;
    logic [NUM_CORES-1:0][CTL_W-1:0]     tctl_q;
    logic [NUM_CORES-1:0][CTL_W-1:0]     mctl_q;
    logic [NUM_CORES-1:0][SRC_W-1:0]     isrc;
    logic [NUM_CORES-1:0][SRC_W-1:0]     fsrc;
    logic [DATA_W-1:0]                   rdata_d;
    logic [DATA_W-CTL_W-1:0]             wdata_unused;

    assign wdata_unused = bus_wdata[DATA_W-1:CTL_W];

    lir_ctrl_regs #(.NUM_CORES(NUM_CORES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata[CTL_W-1:0]),
        .route_irq (route_irq_tgt),
        .route_fiq (route_fiq_tgt),
        .tctl      (tctl_q),
        .mctl      (mctl_q)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic irq_hit;
        logic fiq_hit;
        assign irq_hit = up_irq && (route_irq_tgt == CORE_IDX_W'(c));
        assign fiq_hit = up_fiq && (route_fiq_tgt == CORE_IDX_W'(c));

        lir_core_steer u_steer (
            .timer      (timer_lvl[c*LOCAL_N +: LOCAL_N]),
            .mbox       (mbox_pend[c*LOCAL_N +: LOCAL_N]),
            .tctl       (tctl_q[c]),
            .mctl       (mctl_q[c]),
            .up_irq_hit (irq_hit),
            .up_fiq_hit (fiq_hit),
            .isrc       (isrc[c]),
            .fsrc       (fsrc[c])
        );

        // Register the per-core output lines from the source vectors.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                core_irq[c] <= 1'b0;
                core_fiq[c] <= 1'b0;
            end else begin
                core_irq[c] <= |isrc[c];
                core_fiq[c] <= |fsrc[c];
            end
        end
    end

    lir_read_mux #(.NUM_CORES(NUM_CORES)) u_rmux (
        .addr      (bus_addr),
        .route_irq (route_irq_tgt),
        .route_fiq (route_fiq_tgt),
        .tctl      (tctl_q),
        .mctl      (mctl_q),
        .isrc      (isrc),
        .fsrc      (fsrc),
        .rdata     (rdata_d)
    );

    // Register read data; zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rdata_d;
        else                bus_rdata <= '0;
    end
endmodule

// File: rtl/lir_router_chk.sv
// Module: assertion checker for local_irq_router, attached by bind.
// Assumes the top's internal names route_*_tgt, tctl_q, mctl_q, isrc, fsrc.
module lir_router_chk
    import lir_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_wr_en,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic                           up_irq,
    input logic                           up_fiq,
    input logic [CORE_IDX_W-1:0]          route_irq_tgt,
    input logic [CORE_IDX_W-1:0]          route_fiq_tgt,
    input logic [NUM_CORES-1:0][CTL_W-1:0] tctl_q,
    input logic [NUM_CORES-1:0][CTL_W-1:0] mctl_q,
    input logic [NUM_CORES-1:0][SRC_W-1:0] isrc,
    input logic [NUM_CORES-1:0][SRC_W-1:0] fsrc,
    input logic [NUM_CORES-1:0]           core_irq,
    input logic [NUM_CORES-1:0]           core_fiq
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (tctl_q == '0 && mctl_q == '0 && route_irq_tgt == '0 &&
                    route_fiq_tgt == '0 && core_irq == '0 && core_fiq == '0));

    // R11
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && lir_region(bus_addr) == RG_NONE) |=>
        ($stable(tctl_q) && $stable(mctl_q) && $stable(route_irq_tgt) &&
         $stable(route_fiq_tgt)));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
        // R8
        up_irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (up_irq && route_irq_tgt == CORE_IDX_W'(c)) |=> core_irq[c]);
        // R8
        up_fiq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (up_fiq && route_fiq_tgt == CORE_IDX_W'(c)) |=> core_fiq[c]);
        // R9
        irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (core_irq[c] == $past(isrc[c] != '0)));
        // R9
        fiq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (core_fiq[c] == $past(fsrc[c] != '0)));
        for (genvar j = 0; j < LOCAL_N; j++) begin : g_j
            // R5
            tmr_fiq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tctl_q[c][j+FIQ_OFS] |-> !isrc[c][TMR_BASE+j]);
            // R5
            mbx_fiq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                mctl_q[c][j+FIQ_OFS] |-> !isrc[c][MBX_BASE+j]);
            // R6
            tmr_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!tctl_q[c][j] && !tctl_q[c][j+FIQ_OFS]) |->
                (!isrc[c][TMR_BASE+j] && !fsrc[c][TMR_BASE+j]));
        end
    end
endmodule

bind local_irq_router lir_router_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr_en     (bus_wr_en),
    .bus_addr      (bus_addr),
    .up_irq        (up_irq),
    .up_fiq        (up_fiq),
    .route_irq_tgt (route_irq_tgt),
    .route_fiq_tgt (route_fiq_tgt),
    .tctl_q        (tctl_q),
    .mctl_q        (mctl_q),
    .isrc          (isrc),
    .fsrc          (fsrc),
    .core_irq      (core_irq),
    .core_fiq      (core_fiq)
);

// File: tb/local_irq_router_tb.sv
// Bench: vector table on core 1 plus directed reset, register and corner tests.
module local_irq_router_tb;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [15:0]   timer_lvl = '0;
    logic [15:0]   mbox_pend = '0;
    logic          up_irq = 1'b0;
    logic          up_fiq = 1'b0;
    logic [NC-1:0] core_irq;
    logic [NC-1:0] core_fiq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    local_irq_router #(.NUM_CORES(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .timer_lvl(timer_lvl), .mbox_pend(mbox_pend), .up_irq(up_irq),
        .up_fiq(up_fiq), .core_irq(core_irq), .core_fiq(core_fiq)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [7:0] tctl;
        logic [7:0] mctl;
        logic [3:0] tim;
        logic [3:0] mb;
        logic       upi;
        logic       upf;
        logic [3:0] route;
        logic [8:0] isrc;
        logic [8:0] fsrc;
        logic [3:0] irq;
        logic [3:0] fiq;
    } vec_t;

    localparam vec_t VECS [8] = '{
        // R4 timers 0,2 to IRQ
        '{4'd4, 8'h0F, 8'h00, 4'b0101, 4'b0000, 1'b0, 1'b0, 4'h0, 9'h005, 9'h000, 4'b0010, 4'b0000},
        // R4 timers 0,1 to FIQ
        '{4'd4, 8'hF0, 8'h00, 4'b0011, 4'b0000, 1'b0, 1'b0, 4'h0, 9'h000, 9'h003, 4'b0000, 4'b0010},
        // R5 both bits on 0,1 -> FIQ only; 2,3 masked
        '{4'd5, 8'h33, 8'h00, 4'b1111, 4'b0000, 1'b0, 1'b0, 4'h0, 9'h000, 9'h003, 4'b0000, 4'b0010},
        // R7 mailbox 0 FIQ, 2,3 IRQ
        '{4'd7, 8'h00, 8'h1C, 4'b0000, 4'b1101, 1'b0, 1'b0, 4'h0, 9'h0C0, 9'h010, 4'b0010, 4'b0010},
        // R8 upstream IRQ to core 1
        '{4'd8, 8'h00, 8'h00, 4'b0000, 4'b0000, 1'b1, 1'b0, 4'h1, 9'h100, 9'h000, 4'b0010, 4'b0000},
        // R8 upstream IRQ to core 3, FIQ to core 1
        '{4'd8, 8'h00, 8'h00, 4'b0000, 4'b0000, 1'b1, 1'b1, 4'h7, 9'h000, 9'h100, 4'b1000, 4'b0010},
        // R6 enabled but idle, nothing pending
        '{4'd6, 8'h0F, 8'hFF, 4'b0000, 4'b0000, 1'b0, 1'b0, 4'h0, 9'h000, 9'h000, 4'b0000, 4'b0000},
        // R9 local IRQ plus upstream FIQ on the same core
        '{4'd9, 8'h02, 8'h00, 4'b0010, 4'b0000, 1'b0, 1'b1, 4'h4, 9'h002, 9'h100, 4'b0010, 4'b0010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        n_chk++;
        n_fail++;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 state straight after reset
        check("R1 irq", {28'b0, core_irq}, 32'h0);
        bus_read(8'h0C, rd); check("R1 route", rd, 32'h0);
        bus_read(8'h4C, rd); check("R1 tctl", rd, 32'h0);

        // Vector table on core 1
        foreach (VECS[i]) begin
            bus_write(8'h0C, {28'b0, VECS[i].route});
            bus_write(8'h44, {24'b0, VECS[i].tctl});
            bus_write(8'h54, {24'b0, VECS[i].mctl});
            timer_lvl = {8'b0, VECS[i].tim, 4'b0};
            mbox_pend = {8'b0, VECS[i].mb, 4'b0};
            up_irq = VECS[i].upi;
            up_fiq = VECS[i].upf;
            settle();
            check($sformatf("R%0d irq out v%0d", VECS[i].req, i), {28'b0, core_irq}, {28'b0, VECS[i].irq});
            check($sformatf("R%0d fiq out v%0d", VECS[i].req, i), {28'b0, core_fiq}, {28'b0, VECS[i].fiq});
            bus_read(8'h64, rd);
            check($sformatf("R10 isrc v%0d", i), rd, {23'b0, VECS[i].isrc});
            bus_read(8'h74, rd);
            check($sformatf("R10 fsrc v%0d", i), rd, {23'b0, VECS[i].fsrc});
        end
        timer_lvl = '0; mbox_pend = '0; up_irq = 1'b0; up_fiq = 1'b0;
        bus_write(8'h0C, 32'h0); bus_write(8'h44, 32'h0); bus_write(8'h54, 32'h0);

        // R2 byte truncation on control registers
        bus_write(8'h48, 32'hABCD_1234);
        bus_read(8'h48, rd); check("R2 tctl", rd, 32'h34);
        bus_write(8'h5C, 32'hFFFF_FF81);
        bus_read(8'h5C, rd); check("R2 mctl", rd, 32'h81);

        // R3 route layout and dropped bits
        bus_write(8'h0C, 32'hFFFF_FFF6);
        bus_read(8'h0C, rd); check("R3 route", rd, 32'h6);

        // R10 source registers ignore writes
        bus_write(8'h60, 32'hFFFF_FFFF);
        bus_write(8'h74, 32'hFFFF_FFFF);
        bus_read(8'h60, rd); check("R10 isrc write ignored", rd, 32'h0);
        bus_read(8'h74, rd); check("R10 fsrc write ignored", rd, 32'h0);
        check("R10 outputs", {28'b0, core_irq | core_fiq}, 32'h0);

        // R11 misaligned and unmapped accesses
        bus_write(8'h49, 32'hFF);
        bus_read(8'h48, rd); check("R11 misaligned write", rd, 32'h34);
        bus_read(8'h49, rd); check("R11 misaligned read", rd, 32'h0);
        bus_write(8'h80, 32'hFFFF_FFFF);
        bus_read(8'h80, rd); check("R11 unmapped read", rd, 32'h0);
        bus_read(8'h08, rd); check("R11 hole read", rd, 32'h0);

        // R12 read data returns to zero after the read cycle
        bus_read(8'h0C, rd);
        @(negedge clk);
        check("R12 idle rdata", bus_rdata, 32'h0);

        // R9 control write concurrent with an active source (core 2 timer 3)
        bus_write(8'h48, 32'h08);
        timer_lvl = 16'h0800;
        settle();
        check("R9 before write", {28'b0, core_irq}, 32'h4);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr_en = 1'b0;
        check("R9 old control at write edge", {28'b0, core_irq}, 32'h4);
        @(negedge clk);
        check("R9 new control next edge", {28'b0, core_irq}, 32'h0);
        timer_lvl = '0;

        // R1 reset clears a configured block
        bus_write(8'h0C, 32'hF);
        bus_write(8'h40, 32'hFF);
        up_irq = 1'b1;
        settle();
        check("R1 pre-reset irq", {28'b0, core_irq}, 32'h8);
        up_irq = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        check("R1 reset outputs", {28'b0, core_irq | core_fiq}, 32'h0);
        bus_read(8'h0C, rd); check("R1 route cleared", rd, 32'h0);
        bus_read(8'h40, rd); check("R1 tctl cleared", rd, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule